// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Burst SRAM

This block is a synthesizable behavioural model of a synchronous single-port SRAM that shares one data bus for reads and writes. The bus never needs an idle cycle when the direction changes. The array is small: 256 words of four 9-bit lanes by default. A write command and a read command put their data on the bus the same number of clock edges after they are sampled, so the host can issue read, write, read, write on consecutive cycles. Each command either loads a fresh address or continues a four-beat burst from the last load. A continued burst steps through the address in linear or interleaved order.

The command side is controlled by a small state machine with four states. ST_IDLE means no burst is open. ST_READ and ST_WRITE mean a selected load has opened a burst in that direction. ST_SNOOZE means the sleep input has frozen the block. The transitions are as follows:
- A selected load moves to ST_READ or ST_WRITE, depending on the direction control.
- A load with any chip enable inactive moves to ST_IDLE.
- A continue keeps the current state.
- Sleep moves any state to ST_SNOOZE.
- The first edge with sleep low moves ST_SNOOZE to ST_IDLE.

Commands then pass through two delay registers. The array is read at the edge that loads the output register. The write completes one edge later, with the data sampled from the bus. A write still in flight is merged into a read of the same word, so the read returns the newest data.

Top module: `zbt_burst_sram`

## Requirements
- R1: A selected load with rd_wr_n=1 sampled at enabled edge k puts the addressed word on d_out after enabled edge k+2. d_out holds that word until the next enabled edge, and d_oe is 1 while oe_n=0.
- R2: A write command sampled at enabled edge k takes d_in at enabled edge k+3, which is the bus cycle a read from edge k would occupy. Lane i is bits 9i+8..9i, and it is written only when bwe_n[i]=0 in the command cycle. d_oe stays 0 during the write's bus cycle.
- R3: A read issued on the edge right after a write to the same address returns the merged new data, with no idle cycle in between.
- R4: With adv=1, the previous burst continues at the next beat and keeps its direction, while rd_wr_n and the chip enables are ignored. Beat n of a burst from base b keeps b[7:2]. It uses b[1:0]+n mod 4 when lin_burst=1 and b[1:0] xor n when lin_burst=0, and it wraps after four beats.
- R5: A load with cs0_n=1, cs1=0 or cs2_n=1 is a deselect. Its bus cycle is undriven, and continues that follow it neither drive nor write.
- R6: An edge with stall=1 changes no state: d_out, d_oe, pending commands and the burst position all hold.
- R7: oe_n=1 forces d_oe to 0 at once and does not disturb the read pipeline.
- R8: While sleep=1, d_oe is 0 and all other inputs are ignored, including write commands. Stored words are kept. Commands pending when sleep rises are dropped.
- R9: After reset d_oe is 0 and no command is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all synchronous inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| stall | input | 1 | 1 masks the clock edge for every register |
| sleep | input | 1 | 1 freezes the block and releases the bus |
| lin_burst | input | 1 | Burst order: 1 linear, 0 interleaved |
| adv | input | 1 | 0 load new address, 1 continue burst |
| rd_wr_n | input | 1 | At a load: 1 read, 0 write |
| cs0_n | input | 1 | Chip enable, active low |
| cs1 | input | 1 | Chip enable, active high |
| cs2_n | input | 1 | Chip enable, active low |
| addr | input | ADDR_W | Word address, sampled at a load |
| bwe_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| d_in | input | LANES*LANE_W | Bus value seen by the block |
| d_out | output | LANES*LANE_W | Registered read data |
| d_oe | output | 1 | Bus drive enable |

## Verification
Every result is due at a fixed count of enabled edges after its command. Read data and its drive enable are due after the second enabled edge, and write data is sampled at the third. The bench keeps a history of commands indexed by its own count of enabled edges. After each edge it looks up the command whose bus cycle has just begun, then checks or drives the bus half a clock later. Stalled edges do not advance the count, so the same expectation is checked again. Sleep clears the history, because commands in flight are dropped.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_WRITE  = 2'd2,
        ST_SNOOZE = 2'd3
    } zbt_state_e;

    // low address bits of a burst beat, from the base bits and beat number
    function automatic logic [BEAT_W-1:0] beat_offset(
        input logic [BEAT_W-1:0] base_lo,
        input logic [BEAT_W-1:0] beat,
        input logic              linear
    );
        if (linear) begin
            return base_lo + beat;
        end
        return base_lo ^ beat;
    endfunction

endpackage

// File: rtl/zbt_burst_ctrl.sv
module zbt_burst_ctrl
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              sleep,
    input  logic              lin,
    input  logic              sel,
    input  logic              rd,
    input  logic              adv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  bwe_n,
    output logic              cmd_vld,
    output logic              cmd_wr,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LANES-1:0]  cmd_bwe_n
);

    zbt_state_e          state_q, state_d;
    logic [ADDR_W-1:0]   base_q, base_d;
    logic [BEAT_W-1:0]   cnt_q, cnt_d;
    logic [BEAT_W-1:0]   cnt_inc;
    logic                vld_d, wr_d;
    logic [ADDR_W-1:0]   addr_d;
    logic [LANES-1:0]    bwe_d;

    assign cnt_inc = cnt_q + BEAT_W'(1);

    always_comb begin
        state_d = state_q;
        base_d  = base_q;
        cnt_d   = cnt_q;
        vld_d   = cmd_vld;
        wr_d    = cmd_wr;
        addr_d  = cmd_addr;
        bwe_d   = cmd_bwe_n;
        if (sleep) begin
            state_d = ST_SNOOZE;
            vld_d   = 1'b0;
        end else begin
            unique case (state_q)
                ST_SNOOZE: begin
                    state_d = ST_IDLE;
                    vld_d   = 1'b0;
                end
                ST_IDLE, ST_READ, ST_WRITE: begin
                    if (step) begin
                        if (!adv) begin
                            vld_d   = sel;
                            wr_d    = !rd;
                            addr_d  = addr;
                            bwe_d   = bwe_n;
                            base_d  = addr;
                            cnt_d   = '0;
                            state_d = !sel ? ST_IDLE : (rd ? ST_READ : ST_WRITE);
                        end else if (state_q == ST_IDLE) begin
                            vld_d = 1'b0;
                        end else begin
                            cnt_d  = cnt_inc;
                            vld_d  = 1'b1;
                            wr_d   = (state_q == ST_WRITE);
                            addr_d = {base_q[ADDR_W-1:BEAT_W],
                                      beat_offset(base_q[BEAT_W-1:0], cnt_inc, lin)};
                            bwe_d  = bwe_n;
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register and burst position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            base_q  <= base_d;
            cnt_q   <= cnt_d;
        end
    end

    // issued command register (first pipeline stage)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_vld   <= 1'b0;
            cmd_wr    <= 1'b0;
            cmd_addr  <= '0;
            cmd_bwe_n <= '1;
        end else begin
            cmd_vld   <= vld_d;
            cmd_wr    <= wr_d;
            cmd_addr  <= addr_d;
            cmd_bwe_n <= bwe_d;
        end
    end

endmodule

// File: rtl/zbt_stage.sv
module zbt_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         flush,
    input  logic         d_vld,
    input  logic [W-1:0] d,
    output logic         q_vld,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_vld <= 1'b0;
            q     <= '0;
        end else if (flush) begin
            q_vld <= 1'b0;
        end else if (step) begin
            q_vld <= d_vld;
            q     <= d;
        end
    end

endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step,
    input  logic                    flush,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        wr_bwe_n,
    input  logic [LANES*LANE_W-1:0] wr_data,
    output logic [LANES*LANE_W-1:0] q,
    output logic                    q_drive
);

    localparam int DATA_W = LANES * LANE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] merged;
    logic              hit;

    assign rd_word = mem[rd_addr];
    assign hit     = wr_en && (wr_addr == rd_addr);

    // a write committing on this edge overrides the stale lanes of the read
    for (genvar l = 0; l < LANES; l++) begin : g_merge
        assign merged[l*LANE_W +: LANE_W] = (hit && !wr_bwe_n[l])
            ? wr_data[l*LANE_W +: LANE_W]
            : rd_word[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
        if (step && !flush && wr_en) begin
            for (int l = 0; l < LANES; l++) begin
                if (!wr_bwe_n[l]) begin
                    mem[wr_addr][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q_drive <= 1'b0;
        end else if (flush) begin
            q_drive <= 1'b0;
        end else if (step) begin
            q_drive <= rd_en;
            if (rd_en) begin
                q <= merged;
            end
        end
    end

endmodule

// File: rtl/zbt_burst_sram.sv
module zbt_burst_sram
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    stall,
    input  logic                    sleep,
    input  logic                    lin_burst,
    input  logic                    adv,
    input  logic                    rd_wr_n,
    input  logic                    cs0_n,
    input  logic                    cs1,
    input  logic                    cs2_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        bwe_n,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] d_in,
    output logic [LANES*LANE_W-1:0] d_out,
    output logic                    d_oe
);

    localparam int DATA_W = LANES * LANE_W;
    localparam int PAY_W  = 1 + ADDR_W + LANES;
    localparam int DELAYS = 2;

    logic step;
    logic sel;
    logic q_drive;

    logic              c_vld, c_wr;
    logic [ADDR_W-1:0] c_addr;
    logic [LANES-1:0]  c_bwe_n;

    logic             pv  [DELAYS+1];
    logic [PAY_W-1:0] pay [DELAYS+1];

    assign step = !stall;
    assign sel  = !cs0_n && cs1 && !cs2_n;

    zbt_burst_ctrl #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .sleep     (sleep),
        .lin       (lin_burst),
        .sel       (sel),
        .rd        (rd_wr_n),
        .adv       (adv),
        .addr      (addr),
        .bwe_n     (bwe_n),
        .cmd_vld   (c_vld),
        .cmd_wr    (c_wr),
        .cmd_addr  (c_addr),
        .cmd_bwe_n (c_bwe_n)
    );

    assign pv[0]  = c_vld;
    assign pay[0] = {c_wr, c_addr, c_bwe_n};

    // address/control delay registers between command and bus cycle
    for (genvar i = 0; i < DELAYS; i++) begin : g_delay
        zbt_stage #(
            .W (PAY_W)
        ) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .step  (step),
            .flush (sleep),
            .d_vld (pv[i]),
            .d     (pay[i]),
            .q_vld (pv[i+1]),
            .q     (pay[i+1])
        );
    end

    logic              rd_en, wr_en;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [LANES-1:0]  wr_bwe_n;

    assign rd_en    = pv[DELAYS-1] && !pay[DELAYS-1][PAY_W-1];
    assign rd_addr  = pay[DELAYS-1][LANES +: ADDR_W];
    assign wr_en    = pv[DELAYS] && pay[DELAYS][PAY_W-1];
    assign wr_addr  = pay[DELAYS][LANES +: ADDR_W];
    assign wr_bwe_n = pay[DELAYS][LANES-1:0];

    zbt_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .flush    (sleep),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_bwe_n (wr_bwe_n),
        .wr_data  (d_in),
        .q        (d_out),
        .q_drive  (q_drive)
    );

    assign d_oe = q_drive && !oe_n && !sleep;

endmodule

// File: rtl/zbt_burst_sram_chk.sv
module zbt_burst_sram_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stall,
    input logic              sleep,
    input logic              adv,
    input logic              rd_wr_n,
    input logic              cs0_n,
    input logic              cs1,
    input logic              cs2_n,
    input logic              oe_n,
    input logic [DATA_W-1:0] d_out,
    input logic              d_oe
);

    logic [2:0] age;
    logic       sel;
    logic       go;

    assign sel = !cs0_n && cs1 && !cs2_n;
    assign go  = !stall && !sleep;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= '0;
        end else if (age != 3'd4) begin
            age <= age + 3'd1;
        end
    end

    // R1: a selected read load drives the bus after two further enabled edges
    assert_read_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 3'd4 && !$past(sleep, 4) && $past(go, 3) && !$past(adv, 3)
         && $past(sel, 3) && $past(rd_wr_n, 3) && $past(go, 2) && $past(go, 1)
         && !oe_n && !sleep) |-> d_oe);

    // R2: the bus cycle of a write command is never driven
    assert_write_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 3'd4 && $past(go, 3) && !$past(adv, 3) && $past(sel, 3)
         && !$past(rd_wr_n, 3) && $past(go, 2) && $past(go, 1)) |-> !d_oe);

    // R5: a deselect load leaves its bus cycle undriven
    assert_dsel_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 3'd4 && $past(go, 3) && !$past(adv, 3) && !$past(sel, 3)
         && $past(go, 2) && $past(go, 1)) |-> !d_oe);

    // R6: a masked edge leaves the output register unchanged
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !sleep) |=> $stable(d_out));

    // R8: pending reads are dropped, so the bus is free when sleep ends
    assert_wake_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 3'd0 && $fell(sleep)) |-> !d_oe);

endmodule

bind zbt_burst_sram zbt_burst_sram_chk #(
    .DATA_W ($bits(d_out))
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .stall   (stall),
    .sleep   (sleep),
    .adv     (adv),
    .rd_wr_n (rd_wr_n),
    .cs0_n   (cs0_n),
    .cs1     (cs1),
    .cs2_n   (cs2_n),
    .oe_n    (oe_n),
    .d_out   (d_out),
    .d_oe    (d_oe)
);

// File: tb/zbt_burst_sram_tb.sv
module zbt_burst_sram_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stall = 1'b0, sleep = 1'b0, lin_burst = 1'b1;
    logic          adv = 1'b0, rd_wr_n = 1'b1;
    logic          cs0_n = 1'b1, cs1 = 1'b0, cs2_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [NL-1:0] bwe_n = '1;
    logic          oe_n = 1'b0;
    logic [DW-1:0] d_in = '0;
    logic [DW-1:0] d_out;
    logic          d_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    zbt_burst_sram u_dut (
        .clk(clk), .rst_n(rst_n), .stall(stall), .sleep(sleep),
        .lin_burst(lin_burst), .adv(adv), .rd_wr_n(rd_wr_n),
        .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n), .addr(addr),
        .bwe_n(bwe_n), .oe_n(oe_n), .d_in(d_in), .d_out(d_out), .d_oe(d_oe)
    );

    int total = 0;
    int bad = 0;

    logic [DW-1:0] model [1 << AW];
    // command history by enabled-edge number; code 0 load, 1 burst beat, 2 read right after write
    logic          h_vld [8];
    logic          h_wr [8];
    logic [AW-1:0] h_addr [8];
    logic [NL-1:0] h_bwe [8];
    int            h_code [8];
    int            ne = 0;
    int            mode = 0;      // 0 none, 1 read burst, 2 write burst
    logic [AW-1:0] b_base = '0;
    int            b_cnt = 0;

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic chk_w(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s d_out act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic chk_b(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s d_oe act=%b exp=%b", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] b, input int n, input logic l);
        logic [1:0] lo;
        lo = l ? 2'(b[1:0] + 2'(n)) : (b[1:0] ^ 2'(n));
        return {b[AW-1:2], lo};
    endfunction

    task automatic clear_hist();
        for (int i = 0; i < 8; i++) h_vld[i] = 1'b0;
        mode = 0;
    endtask

    task automatic record(input logic v, input logic w, input logic [AW-1:0] a,
                          input logic [NL-1:0] bw, input int code);
        int p = (ne + 7) % 8;
        int c = code;
        if (v && !w && h_vld[p] && h_wr[p] && h_addr[p] == a) c = 2;
        h_vld[ne % 8]  = v;
        h_wr[ne % 8]   = w;
        h_addr[ne % 8] = a;
        h_bwe[ne % 8]  = bw;
        h_code[ne % 8] = c;
    endtask

    // bus cycle of the command from enabled edge ne-2
    task automatic data_phase(input logic new_edge);
        int j = (ne + 6) % 8;
        if (sleep) begin
            chk_b("R8", d_oe, 1'b0);
        end else if (ne < 2 || !h_vld[j]) begin
            chk_b("R5", d_oe, 1'b0);
        end else if (h_wr[j]) begin
            if (new_edge) begin
                logic [DW-1:0] v = DW'({$urandom(), $urandom()});
                d_in = v;
                for (int l = 0; l < NL; l++)
                    if (!h_bwe[j][l]) model[h_addr[j]][l*LW +: LW] = v[l*LW +: LW];
            end
            chk_b("R2", d_oe, 1'b0);
        end else begin
            string tag;
            if (!new_edge)            tag = "R6";
            else if (oe_n)            tag = "R7";
            else if (h_code[j] == 2)  tag = "R3";
            else if (h_code[j] == 1)  tag = "R4";
            else                      tag = "R1";
            chk_b(tag, d_oe, !oe_n);
            chk_w(tag, d_out, model[h_addr[j]]);
        end
    endtask

    task automatic tick(input logic st, input logic ad, input logic rd, input logic sl,
                        input logic [AW-1:0] a, input logic [NL-1:0] bw,
                        input logic oe, input logic zz);
        logic new_e;
        stall = st; adv = ad; rd_wr_n = rd; addr = a; bwe_n = bw; oe_n = oe; sleep = zz;
        if (sl) begin
            {cs0_n, cs1, cs2_n} = 3'b010;
        end else begin
            case ($urandom_range(2))
                0:       {cs0_n, cs1, cs2_n} = 3'b110;
                1:       {cs0_n, cs1, cs2_n} = 3'b000;
                default: {cs0_n, cs1, cs2_n} = 3'b011;
            endcase
        end
        @(posedge clk);
        new_e = 1'b0;
        if (zz) begin
            clear_hist();
        end else if (!st) begin
            ne++;
            new_e = 1'b1;
            if (!ad) begin
                if (sl) begin
                    mode = rd ? 1 : 2; b_base = a; b_cnt = 0;
                    record(1'b1, !rd, a, bw, 0);
                end else begin
                    mode = 0;
                    record(1'b0, 1'b0, a, bw, 0);
                end
            end else if (mode != 0) begin
                b_cnt = (b_cnt + 1) % 4;
                record(1'b1, mode == 2, beat_addr(b_base, b_cnt, lin_burst), bw, 1);
            end else begin
                record(1'b0, 1'b0, a, bw, 0);
            end
        end
        @(negedge clk);
        data_phase(new_e);
    endtask

    task automatic ld(input logic rd, input logic [AW-1:0] a, input logic [NL-1:0] bw);
        tick(1'b0, 1'b0, rd, 1'b1, a, bw, 1'b0, 1'b0);
    endtask

    // continue beat with random (ignored) direction, enables and address: R4
    task automatic cont(input logic [NL-1:0] bw);
        tick(1'b0, 1'b1, 1'($urandom_range(1)), 1'($urandom_range(1)),
             AW'($urandom_range(255)), bw, 1'b0, 1'b0);
    endtask

    task automatic dsel();
        tick(1'b0, 1'b0, 1'b1, 1'b0, '0, '1, 1'b0, 1'b0);
    endtask

    task automatic rnd_tick();
        logic          st = ($urandom_range(9) == 0);
        logic          ad = ($urandom_range(9) < 4);
        logic          rd = 1'($urandom_range(1));
        logic          sl = ($urandom_range(7) != 0);
        logic [AW-1:0] a  = AW'($urandom_range(15));
        logic [NL-1:0] bw = ($urandom_range(2) == 0) ? NL'($urandom_range(15)) : '0;
        logic          oe = ($urandom_range(9) == 0);
        tick(st, ad, rd, sl, a, bw, oe, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        clear_hist();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk_b("R9", d_oe, 1'b0);
        dsel();
        dsel();

        // fill the working range with full-word writes
        for (int a = 0; a < 16; a++) ld(1'b0, AW'(a), '0);
        dsel(); dsel(); dsel();

        // R3: alternate write and read of the same word, then a partial-lane write
        ld(1'b0, 8'd5, 4'b0000);
        ld(1'b1, 8'd5, 4'b1111);
        ld(1'b0, 8'd5, 4'b1010);
        ld(1'b1, 8'd5, 4'b0000);
        ld(1'b1, 8'd6, 4'b0000);
        ld(1'b0, 8'd6, 4'b0110);
        ld(1'b1, 8'd6, 4'b0000);

        // R4: linear read burst from base 6, five beats so it wraps
        ld(1'b1, 8'd6, '0);
        repeat (4) cont('0);
        dsel(); dsel(); dsel();

        // R6: read followed by stalled edges
        ld(1'b1, 8'd2, '0);
        dsel();
        tick(1'b1, 1'b0, 1'b1, 1'b1, 8'd9, '0, 1'b0, 1'b0);
        tick(1'b1, 1'b0, 1'b0, 1'b1, 8'd9, '0, 1'b0, 1'b0);
        dsel();
        tick(1'b1, 1'b1, 1'b0, 1'b1, 8'd3, '0, 1'b1, 1'b0);
        dsel(); dsel();

        // R5: a deselect followed by continues neither drives nor writes
        dsel();
        cont('0);
        cont('0);
        dsel(); dsel();

        for (int i = 0; i < 500; i++) rnd_tick();
        dsel(); dsel(); dsel();

        // R4: interleaved write burst with varying lanes, then read it back
        lin_burst = 1'b0;
        ld(1'b0, 8'd9, 4'b0000);
        cont(4'b0011);
        cont(4'b1100);
        cont(4'b0101);
        ld(1'b1, 8'd10, '0);
        repeat (3) cont('0);
        dsel(); dsel(); dsel();

        for (int i = 0; i < 500; i++) rnd_tick();
        dsel(); dsel(); dsel();

        // R8: sleep with write attempts and oe_n low, then read everything back
        for (int i = 0; i < 5; i++)
            tick(1'b0, 1'b0, 1'b0, 1'b1, AW'(i), '0, 1'b0, 1'b1);
        dsel();
        dsel();
        lin_burst = 1'b1;
        for (int a = 0; a < 16; a++) ld(1'b1, AW'(a), '0);
        dsel(); dsel(); dsel();

        finish_up();
    end

endmodule